// File: doc/BRIEF.md
# Power-Good Latch and Power-Down Sequencer

This block sits behind a single dual-role board pin of a clock generator. Before the supplies are declared good, the pin is a power-good strobe. The first time it is seen high, the block takes one snapshot of the frequency-select strap and moves to a lock wait. From then on, the same pin is read as an active-low power-down request.

A power-down request is synchronized into the clock domain. The block then closes the gate of every clock output. Each gate closes only while that output's own clock phase is low, so no output is cut short. Differential pairs end with both legs low.

Once every gate is closed, the block can pulse a register-clear line, so that the configuration falls back to defaults. A restore bit decides whether that happens. When the pin returns high, the block waits for the PLL lock indication, or for a timeout as a fallback. It then reopens each gate at a low phase of that output's clock.

The output clocks are modelled as phase levels sampled in the block's own clock domain. Gating is an AND of each phase with its registered enable.

Top module: `pgs_top`

## Requirements
- R1: Until the pin has been captured high, every enable (`se_en`, `dif_en`) is 0, every clock output is low and `cfg_clr` stays 0. A low pin and `pll_lock` have no effect in this phase.
- R2: The pin counts as high when it is sampled high on two consecutive clock edges. On the first such event, `fsel` takes the synchronized strap value, with 0 meaning the 133 MHz CPU rate and 1 meaning 100 MHz. `fsel` is valid on the third rising edge after the pin rises.
- R3: After capture with `test_mode` = 0, `fsel` holds its value. Later strap changes and pin transitions do not alter it.
- R4: With `test_mode` = 1, `fsel` follows the synchronized strap whenever the pin is seen high.
- R5: After capture, power-down is recognized only when the pin is sampled low on two consecutive edges. A low pulse of a single cycle changes nothing.
- R6: During power-down, an enable falls only on an edge at which its phase input was low. An enable never changes on an edge at which its phase was high. A differential pair with its enable at 0 drives both `dif_t` and `dif_c` low.
- R7: When power-down completes, `cfg_clr` pulses high for exactly one cycle if `restore_cfg` = 0, and not at all if `restore_cfg` = 1.
- R8: After the pin is seen high again, the enables stay 0 until `pll_lock` is sampled high. Each enable then opens at a low phase of its own output.
- R9: If `pll_lock` stays low, the outputs are enabled anyway once LOCK_TMO cycles have passed in the lock wait.
- R10: A power-down request during the lock wait returns the block to power-down without opening any gate. It also issues the clear pulse when `restore_cfg` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (CPU clock domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgpd_pin | input | 1 | Dual-role pin: power-good strobe, then active-low power-down |
| fs_strap | input | 1 | Frequency-select strap level |
| test_mode | input | 1 | Allows strap re-capture while high |
| pll_lock | input | 1 | PLL lock indication |
| restore_cfg | input | 1 | 1 keeps configuration over power-down, 0 clears it |
| se_ph | input | N_SE | Phase levels of the single-ended output clocks |
| dif_ph | input | N_DIF | True-leg phase levels of the differential output clocks |
| fsel | output | 1 | Latched frequency select (0 = 133 MHz, 1 = 100 MHz) |
| se_en | output | N_SE | Gate enables, single-ended outputs |
| dif_en | output | N_DIF | Gate enables, differential outputs |
| se_o | output | N_SE | Gated single-ended clocks |
| dif_t | output | N_DIF | Gated differential true legs |
| dif_c | output | N_DIF | Gated differential complement legs |
| cfg_clr | output | 1 | One-cycle register-clear pulse |

## Verification
A pin change applied before edge k reaches the second synchronizer stage after edge k+1. The control state moves at edge k+2, so `fsel` is sampled exactly after three edges, and checked still unchanged after two. An enable follows the control state one edge later when its phase is held low. The bench therefore checks enables a fixed two edges after a request, while they must still be open, and again some edges later, when they must have settled. The timeout is bracketed several cycles either side of LOCK_TMO. Glitch-freedom and the clear pulse are checked on every clock step: the bench compares each enable change with the phase that was applied before that edge, and it counts clear pulses over each power-down window.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
    typedef enum logic [2:0] {
        ST_WAIT_PG = 3'd0,
        ST_LOCK    = 3'd1,
        ST_RUN     = 3'd2,
        ST_GATE    = 3'd3,
        ST_OFF     = 3'd4
    } pgs_state_e;

    typedef struct packed {
        pgs_state_e state;
        logic       fsel;
        logic       clr;
    } pgs_regs_t;
endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] s1,
    output logic [W-1:0] s2
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = d;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign s1 = s1_q;
    assign s2 = s2_q;
endmodule

// File: rtl/pgs_gate.sv
module pgs_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic want_on,
    input  logic ph,
    output logic en
);
    logic en_d, en_q;

    // the enable may only move while the output's own phase is low
    always_comb begin
        en_d = ph ? en_q : want_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign en = en_q;
endmodule

// File: rtl/pgs_lock_timer.sv
module pgs_lock_timer #(
    parameter int TMO = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TMO + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)              cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = cnt_q;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/pgs_top.sv
module pgs_top
    import pgs_pkg::*;
#(
    parameter int N_SE     = 3,
    parameter int N_DIF    = 4,
    parameter int LOCK_TMO = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pgpd_pin,
    input  logic             fs_strap,
    input  logic             test_mode,
    input  logic             pll_lock,
    input  logic             restore_cfg,
    input  logic [N_SE-1:0]  se_ph,
    input  logic [N_DIF-1:0] dif_ph,
    output logic             fsel,
    output logic [N_SE-1:0]  se_en,
    output logic [N_DIF-1:0] dif_en,
    output logic [N_SE-1:0]  se_o,
    output logic [N_DIF-1:0] dif_t,
    output logic [N_DIF-1:0] dif_c,
    output logic             cfg_clr
);
    localparam int N_OUT = N_SE + N_DIF;

    logic [1:0]       s1, s2;
    logic             pin_hi, pin_lo, strap_s;
    logic             want_on, all_off, tmo_expired;
    logic [N_OUT-1:0] ph_all, en_all;
    pgs_regs_t        r_d, r_q;

    pgs_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({fs_strap, pgpd_pin}),
        .s1    (s1),
        .s2    (s2)
    );

    assign pin_hi  = s1[0] & s2[0];
    assign pin_lo  = ~s1[0] & ~s2[0];
    assign strap_s = s2[1];

    pgs_lock_timer #(.TMO(LOCK_TMO)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.state == ST_LOCK),
        .expired (tmo_expired)
    );

    assign ph_all  = {dif_ph, se_ph};
    assign want_on = (r_q.state == ST_RUN);

    for (genvar g = 0; g < N_OUT; g++) begin : g_gate
        pgs_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .want_on (want_on),
            .ph      (ph_all[g]),
            .en      (en_all[g])
        );
    end

    assign all_off = ~|en_all;

    always_comb begin
        r_d     = r_q;
        r_d.clr = 1'b0;
        case (r_q.state)
            ST_WAIT_PG: begin
                if (pin_hi) begin
                    r_d.fsel  = strap_s;
                    r_d.state = ST_LOCK;
                end
            end
            ST_LOCK: begin
                if (pin_lo) begin
                    r_d.state = ST_OFF;
                    r_d.clr   = ~restore_cfg;
                end else if (pll_lock || tmo_expired) begin
                    r_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (pin_lo) r_d.state = ST_GATE;
            end
            ST_GATE: begin
                if (all_off) begin
                    r_d.state = ST_OFF;
                    r_d.clr   = ~restore_cfg;
                end
            end
            ST_OFF: begin
                if (pin_hi) r_d.state = ST_LOCK;
            end
            default: r_d.state = ST_WAIT_PG;
        endcase
        if (r_q.state != ST_WAIT_PG && test_mode && pin_hi)
            r_d.fsel = strap_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_WAIT_PG;
            r_q.fsel  <= 1'b0;
            r_q.clr   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fsel    = r_q.fsel;
    assign cfg_clr = r_q.clr;
    assign se_en   = en_all[N_SE-1:0];
    assign dif_en  = en_all[N_OUT-1:N_SE];
    assign se_o    = se_ph & se_en;
    assign dif_t   = dif_ph & dif_en;
    assign dif_c   = ~dif_ph & dif_en;
endmodule

// File: rtl/pgs_chk.sv
module pgs_chk
    import pgs_pkg::*;
#(
    parameter int N_SE  = 3,
    parameter int N_DIF = 4
) (
    input logic             clk,
    input logic             rst_n,
    input pgs_state_e       state,
    input logic             tmo_expired,
    input logic             test_mode,
    input logic             pll_lock,
    input logic             restore_cfg,
    input logic [N_SE-1:0]  se_ph,
    input logic [N_DIF-1:0] dif_ph,
    input logic [N_SE-1:0]  se_en,
    input logic [N_DIF-1:0] dif_en,
    input logic             fsel,
    input logic             cfg_clr
);
    a_r1_closed_before_pg: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_PG) |-> (se_en == '0 && dif_en == '0 && !cfg_clr));

    a_r3_fsel_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WAIT_PG && !test_mode) |=> $stable(fsel));

    a_r6_se_glitch_free: assert property (@(posedge clk) disable iff (!rst_n)
        ((se_en ^ $past(se_en)) & $past(se_ph)) == '0);

    a_r6_dif_glitch_free: assert property (@(posedge clk) disable iff (!rst_n)
        ((dif_en ^ $past(dif_en)) & $past(dif_ph)) == '0);

    a_r7_clr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clr |=> !cfg_clr);

    a_r7_clr_needs_no_restore: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clr |-> !$past(restore_cfg));

    a_r8_run_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_LOCK) |-> ($past(pll_lock) || $past(tmo_expired)));
endmodule

bind pgs_top pgs_chk #(.N_SE(N_SE), .N_DIF(N_DIF)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (r_q.state),
    .tmo_expired (tmo_expired),
    .test_mode   (test_mode),
    .pll_lock    (pll_lock),
    .restore_cfg (restore_cfg),
    .se_ph       (se_ph),
    .dif_ph      (dif_ph),
    .se_en       (se_en),
    .dif_en      (dif_en),
    .fsel        (fsel),
    .cfg_clr     (cfg_clr)
);

// File: tb/tb_pgs_top.sv
module tb_pgs_top;
    localparam int N_SE  = 3;
    localparam int N_DIF = 4;
    localparam int TMO   = 40;
    localparam int NO    = N_SE + N_DIF;

    logic clk = 1'b0;
    logic rst_n, pgpd_pin, fs_strap, test_mode, pll_lock, restore_cfg;
    logic [N_SE-1:0]  se_ph, se_en, se_o;
    logic [N_DIF-1:0] dif_ph, dif_en, dif_t, dif_c;
    logic fsel, cfg_clr;

    int n_tests = 0, n_fail = 0;
    int glitch_cnt = 0, dif_bad = 0, clr_cnt = 0, cyc = 0, pat = 0;
    bit toggle = 0, done = 0;

    always #4 clk = ~clk;

    pgs_top #(.N_SE(N_SE), .N_DIF(N_DIF), .LOCK_TMO(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .pgpd_pin(pgpd_pin), .fs_strap(fs_strap),
        .test_mode(test_mode), .pll_lock(pll_lock), .restore_cfg(restore_cfg),
        .se_ph(se_ph), .dif_ph(dif_ph), .fsel(fsel), .se_en(se_en),
        .dif_en(dif_en), .se_o(se_o), .dif_t(dif_t), .dif_c(dif_c),
        .cfg_clr(cfg_clr)
    );

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            logic [NO-1:0] ph_prev, en_prev;
            ph_prev = {dif_ph, se_ph};
            en_prev = {dif_en, se_en};
            @(posedge clk);
            @(negedge clk);
            if ((({dif_en, se_en} ^ en_prev) & ph_prev) != '0) glitch_cnt++;
            if (((dif_t | dif_c) & ~dif_en) != '0) dif_bad++;
            if ((se_o & ~se_en) != '0) dif_bad++;
            if (cfg_clr) clr_cnt++;
            cyc++;
            if (toggle) begin
                logic [NO-1:0] p;
                for (int i = 0; i < NO; i++)
                    p[i] = 1'(((cyc + pat * i) >> (i % 3)) & 1);
                {dif_ph, se_ph} = p;
            end
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] en_vec();
        return 32'({dif_en, se_en});
    endfunction

    localparam logic [31:0] ALL = (32'd1 << NO) - 1;

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; pgpd_pin = 0; fs_strap = 0; test_mode = 0;
        pll_lock = 0; restore_cfg = 0; se_ph = '0; dif_ph = '0;
        step(3);
        rst_n = 1;
        step(1);
        // R1 reset state
        check("R1 reset enables", en_vec(), 0);
        check("R1 reset fsel", 32'(fsel), 0);
        check("R1 reset clr", 32'(cfg_clr), 0);
        // R1 pin low, lock high before capture
        pll_lock = 1; clr_cnt = 0;
        step(20);
        check("R1 no enable before pg", en_vec(), 0);
        check("R1 no clear before pg", clr_cnt, 0);
        check("R1 outputs low", 32'({dif_t, dif_c, se_o}), 0);
        // R2 capture strap = 1
        fs_strap = 1; step(1);
        pgpd_pin = 1;
        step(2);
        check("R2 fsel not yet", 32'(fsel), 0);
        step(1);
        check("R2 fsel latched 100MHz", 32'(fsel), 1);
        step(2);
        check("R8 enabled with lock", en_vec(), ALL);
        // R3 strap change ignored
        fs_strap = 0; step(5);
        check("R3 strap ignored", 32'(fsel), 1);
        // R5 single-cycle low ignored
        clr_cnt = 0; pgpd_pin = 0; step(1); pgpd_pin = 1; step(8);
        check("R5 short low ignored", en_vec(), ALL);
        check("R5 no clear on short low", clr_cnt, 0);
        // R6 hold one phase high, restore=1
        restore_cfg = 1; clr_cnt = 0; se_ph[0] = 1;
        pgpd_pin = 0;
        step(2);
        check("R5 enables still open two edges after", en_vec(), ALL);
        step(5);
        check("R6 high phase keeps enable", en_vec(), 1);
        check("R6 diff legs low", 32'({dif_t, dif_c}), 0);
        se_ph[0] = 0; step(3);
        check("R6 enable closes at low phase", en_vec(), 0);
        step(5);
        check("R7 no clear with restore", clr_cnt, 0);
        check("R3 fsel kept over pd", 32'(fsel), 1);
        // R8 release waits for lock
        pll_lock = 0; pgpd_pin = 1; step(10);
        check("R8 wait for lock", en_vec(), 0);
        pll_lock = 1; step(3);
        check("R8 enable after lock", en_vec(), ALL);
        // R7 clear pulse
        restore_cfg = 0; clr_cnt = 0; pgpd_pin = 0; step(10);
        check("R7 one clear pulse", clr_cnt, 1);
        check("R7 all closed", en_vec(), 0);
        // R9 timeout
        pll_lock = 0; pgpd_pin = 1; step(TMO - 4);
        check("R9 before timeout", en_vec(), 0);
        step(12);
        check("R9 after timeout", en_vec(), ALL);
        // R10 pd during lock wait
        pgpd_pin = 0; step(10);
        pgpd_pin = 1; step(6);
        clr_cnt = 0; pgpd_pin = 0; step(TMO + 10);
        check("R10 stays closed", en_vec(), 0);
        check("R10 clear pulse", clr_cnt, 1);
        // R4 test mode re-capture
        pll_lock = 1; test_mode = 1; fs_strap = 0; pgpd_pin = 1; step(6);
        check("R4 follows strap 0", 32'(fsel), 0);
        fs_strap = 1; step(5);
        check("R4 follows strap 1", 32'(fsel), 1);
        test_mode = 0; fs_strap = 0; step(5);
        check("R3 held after test mode", 32'(fsel), 1);
        // R6 sweep with toggling phases
        restore_cfg = 1;
        for (int p = 0; p < 4; p++) begin
            pat = p; toggle = 1;
            pgpd_pin = 0; step(30);
            check("R6 sweep closed", en_vec(), 0);
            pgpd_pin = 1; step(30);
            check("R8 sweep reopened", en_vec(), ALL);
        end
        toggle = 0;
        check("R6 no glitch", glitch_cnt, 0);
        check("R6 gated legs low", dif_bad, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule